// File: doc/BRIEF.md
# Programmable Down-Counter with Edge-Deferred Run Control

This block holds two 8-bit down-counters that step on the falling edges of a slow input clock. Counter 0 counts either a prescaled timebase or an external event line. Counter 1 counts the prescaled timebase on its own, or, when the two are cascaded into a 16-bit counter, it steps once each time counter 0 underflows. When a counter passes below zero it reloads from its own reload register and gives a one-cycle underflow pulse.

Software starts and stops a counter by writing a run bit. The write does not act at once. The counter takes up the new run state only at the next falling edge of its input clock. A stop still lets that edge decrement the counter one last time. The run read-back shows the state the counter is really in, not the value software last wrote.

Software reads the count one 4-bit nibble at a time. Reading a low nibble captures the rest of the counter value, so the nibbles read after it stay consistent for a set number of system cycles. Both input clocks pass through synchronizers into the system clock domain. Each falling edge then becomes a one-cycle enable.

Top module: `pdc_timer`

## Requirements
- R1: After reset both counts read 0, both run read-back bits are 0, both underflow outputs are 0 and rd_data is 0.
- R2: Writing 1 to a run bit has no effect until the next falling edge of the selected input clock. Until that edge, run_rd stays 0. That edge starts the counter and does not decrement it.
- R3: While running, the counter decrements by exactly 1 on each falling edge of its input clock and holds its value between edges.
- R4: Writing 0 to a run bit leaves run_rd at 1 until the next falling edge. On that edge the counter decrements once more and then stops (for example 3E becomes 3D), and further edges leave it unchanged.
- R5: With src_evt=1, counter 0 is clocked only by falling edges of evt_clk_i and ignores pre_clk_i. If no event edge arrives after a run write, the run state never changes.
- R6: A decrement from 00 loads the reload register into the counter and raises that counter's underflow bit for exactly one system cycle.
- R7: A reload write while the counter is stopped also presets the count. While the counter is running, the write changes only the reload register.
- R8: With cascade16=1, counter 1 decrements once per counter 0 underflow, whatever its own run bit and pre_clk_i do. underflow[1] pulses when counter 1 decrements from 00.
- R9: rd_data is updated in the cycle after rd_en. rd_addr 0 selects counter 0 bits 3:0, 1 selects counter 0 bits 7:4, 2 selects counter 1 bits 3:0 and 3 selects counter 1 bits 7:4.
- R10: Reading counter 0's low nibble captures counter 0. With cascade16=1 it also captures counter 1. Reading counter 1's low nibble in 8-bit mode captures counter 1. For the WINDOW cycles after the capture, reads of the other nibbles return the captured value.
- R11: Once WINDOW cycles have passed since the capture, a high-nibble read returns the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pre_clk_i | input | 1 | Prescaled timebase, asynchronous |
| evt_clk_i | input | 1 | External event line, asynchronous |
| src_evt | input | 1 | 1: counter 0 counts event edges; 0: prescaled edges |
| cascade16 | input | 1 | 1: join the two counters into one 16-bit counter |
| run_wr | input | 2 | Per-counter run-bit write strobe |
| run_wdata | input | 2 | Per-counter run-bit write value |
| run_rd | output | 2 | Actual run state of each counter |
| reload_wr | input | 2 | Per-counter reload write strobe |
| reload_data | input | 8 | Reload value to write |
| rd_en | input | 1 | Nibble read strobe |
| rd_addr | input | 2 | Nibble select |
| rd_data | output | 4 | Nibble read result, registered |
| underflow | output | 2 | Per-counter underflow pulse |

## Verification
The checker checks on every cycle that a count moves only on a decrement enable or a preset. It also checks that the run read-back changes only on an input-clock edge and that a stop edge lowers the count by one. It checks that underflow pulses last one cycle and coincide with a reload, that a cascaded counter follows counter 0's underflow, and that a capture copies the live count. Other behaviour shows only in the bench's scenarios: the deferred start with no decrement, read-back during a pending stop, a stalled event clock holding the run state, prescaled edges being ignored in event mode, and the end of the capture window.

// File: rtl/pdc_pkg.sv
// Shared definitions for the programmable down-counter block.
// Assumes two counters, each read as two nibbles.
package pdc_pkg;
    typedef enum logic [1:0] {
        SEL_C0_LO = 2'd0,
        SEL_C0_HI = 2'd1,
        SEL_C1_LO = 2'd2,
        SEL_C1_HI = 2'd3
    } rd_sel_e;
endpackage

// File: rtl/pdc_fall_sync.sv
// Brings an asynchronous slow clock into the clk domain through SYNC_LEN
// flops. Emits a one-cycle pulse on each synchronized falling edge.
// Assumes both phases of the input last longer than SYNC_LEN+1 clk cycles.
module pdc_fall_sync #(
    parameter int SYNC_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic fall_o
);
    logic [SYNC_LEN-1:0] sync_q;
    logic                prev_q;

    // Shift chain and previous-sample flop; idle level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_LEN-2:0], async_i};
            prev_q <= sync_q[SYNC_LEN-1];
        end
    end

    // Falling edge: previous sample high, current sample low.
    assign fall_o = prev_q & ~sync_q[SYNC_LEN-1];
endmodule

// File: rtl/pdc_counter.sv
// One down-counter with a reload register. A write to the run bit is held
// as a request and only adopted on a tick. A tick also decrements the
// counter if it was running before that tick. casc_dec decrements the
// counter without looking at the run state.
// Assumes tick and casc_dec are never both active.
module pdc_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             casc_dec,
    input  logic             run_wr,
    input  logic             run_wdata,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_data,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload_q,
    output logic             running,
    output logic             uf
);
    logic run_req;
    logic dec;

    assign dec = (tick & running) | casc_dec;

    // Hold the most recently written run request.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_req <= 1'b0;
        else if (run_wr) run_req <= run_wdata;
    end

    // Reload register written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       reload_q <= '0;
        else if (load_wr) reload_q <= load_data;
    end

    // Count, underflow pulse and the actual run state, which changes only on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            running <= 1'b0;
            uf      <= 1'b0;
        end else begin
            uf <= 1'b0;
            if (dec) begin
                if (count == '0) begin
                    count <= reload_q;
                    uf    <= 1'b1;
                end else begin
                    count <= count - 1'b1;
                end
            end else if (load_wr && !running) begin
                count <= load_data;
            end
            if (tick) running <= run_req;
        end
    end
endmodule

// File: rtl/pdc_snap.sv
// Read-coherence capture. A grab copies the live value and opens a window
// of WINDOW cycles, during which valid is high.
// Assumes WINDOW >= 1.
module pdc_snap #(
    parameter int W      = 8,
    parameter int WINDOW = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         grab,
    input  logic [W-1:0] live,
    output logic [W-1:0] shadow,
    output logic         valid
);
    localparam int WIN_W = $clog2(WINDOW + 1);
    logic [WIN_W-1:0] win_q;

    // Capture the value and run the window down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
            win_q  <= '0;
        end else if (grab) begin
            shadow <= live;
            win_q  <= WIN_W'(WINDOW);
        end else if (win_q != '0) begin
            win_q <= win_q - 1'b1;
        end
    end

    assign valid = (win_q != '0);
endmodule

// File: rtl/pdc_timer.sv
// Top level: two down-counters with deferred run control, selectable
// input clocks, 16-bit cascade and coherent nibble reads.
// Assumes software does not write a run bit in the same cycle as a tick.
module pdc_timer
    import pdc_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int SYNC_LEN = 2,
    parameter int WINDOW   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_clk_i,
    input  logic             evt_clk_i,
    input  logic             src_evt,
    input  logic             cascade16,
    input  logic [1:0]       run_wr,
    input  logic [1:0]       run_wdata,
    output logic [1:0]       run_rd,
    input  logic [1:0]       reload_wr,
    input  logic [CNT_W-1:0] reload_data,
    input  logic             rd_en,
    input  logic [1:0]       rd_addr,
    output logic [3:0]       rd_data,
    output logic [1:0]       underflow
);
    localparam int NIB_W = CNT_W / 2;
    localparam int NCNT  = 2;

    logic                       pre_fall, evt_fall;
    logic [NCNT-1:0]            tick, casc, running, uf, grab, valid;
    logic [NCNT-1:0][CNT_W-1:0] cnt, rld, shadow;
    logic [NIB_W-1:0]           nib;

    pdc_fall_sync #(.SYNC_LEN(SYNC_LEN)) u_pre_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pre_clk_i), .fall_o(pre_fall));
    pdc_fall_sync #(.SYNC_LEN(SYNC_LEN)) u_evt_sync (
        .clk(clk), .rst_n(rst_n), .async_i(evt_clk_i), .fall_o(evt_fall));

    // Choose each counter's tick source and cascade enable.
    always_comb begin
        tick[0] = src_evt ? evt_fall : pre_fall;
        casc[0] = 1'b0;
        tick[1] = cascade16 ? 1'b0 : pre_fall;
        casc[1] = cascade16 & uf[0];
    end

    // Capture triggers for the read-coherence windows.
    always_comb begin
        grab[0] = rd_en && (rd_addr == SEL_C0_LO);
        grab[1] = rd_en && (((rd_addr == SEL_C1_LO) && !(cascade16 && valid[1]))
                         || ((rd_addr == SEL_C0_LO) && cascade16));
    end

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        pdc_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .tick(tick[g]), .casc_dec(casc[g]),
            .run_wr(run_wr[g]), .run_wdata(run_wdata[g]),
            .load_wr(reload_wr[g]), .load_data(reload_data),
            .count(cnt[g]), .reload_q(rld[g]), .running(running[g]), .uf(uf[g]));

        pdc_snap #(.W(CNT_W), .WINDOW(WINDOW)) u_snap (
            .clk(clk), .rst_n(rst_n), .grab(grab[g]), .live(cnt[g]),
            .shadow(shadow[g]), .valid(valid[g]));
    end

    assign run_rd    = running;
    assign underflow = uf;

    // Nibble select: a low nibble of counter 0 is always live.
    always_comb begin
        unique case (rd_addr)
            SEL_C0_LO: nib = cnt[0][NIB_W-1:0];
            SEL_C0_HI: nib = valid[0] ? shadow[0][CNT_W-1:NIB_W] : cnt[0][CNT_W-1:NIB_W];
            SEL_C1_LO: nib = (cascade16 && valid[1]) ? shadow[1][NIB_W-1:0] : cnt[1][NIB_W-1:0];
            default:   nib = valid[1] ? shadow[1][CNT_W-1:NIB_W] : cnt[1][CNT_W-1:NIB_W];
        endcase
    end

    // Register the read result.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= 4'(nib);
    end
endmodule

// File: rtl/pdc_timer_chk.sv
// Assertion checker for pdc_timer, attached with bind below.
module pdc_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       tick,
    input logic [1:0]       casc,
    input logic [1:0]       reload_wr,
    input logic [1:0]       grab,
    input logic [1:0]       run_rd,
    input logic [1:0]       underflow,
    input logic             cascade16,
    input logic [CNT_W-1:0] cnt0,
    input logic [CNT_W-1:0] cnt1,
    input logic [CNT_W-1:0] rld0,
    input logic [CNT_W-1:0] shadow0
);
    // R3
    hold_between_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick[0] && !casc[0] && !reload_wr[0]) |=> $stable(cnt0));

    // R2
    run_moves_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick[0] |=> $stable(run_rd[0]));

    // R4
    stop_extra_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(run_rd[0]) && $past(cnt0) != '0) |-> (cnt0 == $past(cnt0) - 1'b1));

    // R6
    uf_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow[0] |=> !underflow[0]);

    // R6
    uf_reloads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow[0] && !$past(reload_wr[0])) |-> (cnt0 == rld0));

    // R8
    cascade_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade16 && underflow[0] && cnt1 != '0 && !reload_wr[1]) |=> (cnt1 == $past(cnt1) - 1'b1));

    // R10
    snap_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grab[0] |=> (shadow0 == $past(cnt0)));
endmodule

bind pdc_timer pdc_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .casc(casc), .reload_wr(reload_wr),
    .grab(grab), .run_rd(run_rd), .underflow(underflow), .cascade16(cascade16),
    .cnt0(cnt[0]), .cnt1(cnt[1]), .rld0(rld[0]), .shadow0(shadow[0]));

// File: tb/sim_pdc_timer.sv
// Scoreboard bench: read tasks queue the expected nibbles and a monitor
// compares them when rd_data comes out.
module sim_pdc_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pre_clk_i = 1'b1, evt_clk_i = 1'b1;
    logic       src_evt = 1'b0, cascade16 = 1'b0;
    logic [1:0] run_wr = '0, run_wdata = '0, reload_wr = '0;
    logic [7:0] reload_data = '0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = '0;
    logic [1:0] run_rd, underflow;
    logic [3:0] rd_data;

    int total = 0, bad = 0;
    int uf0_n = 0, uf1_n = 0;
    logic rd_seen = 1'b0;
    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    pdc_timer u0 (
        .clk(clk), .rst_n(rst_n), .pre_clk_i(pre_clk_i), .evt_clk_i(evt_clk_i),
        .src_evt(src_evt), .cascade16(cascade16), .run_wr(run_wr), .run_wdata(run_wdata),
        .run_rd(run_rd), .reload_wr(reload_wr), .reload_data(reload_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .underflow(underflow));

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: tracks read strobes and compares results against the queue.
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rst_n) begin
            if (underflow[0]) uf0_n++;
            if (underflow[1]) uf1_n++;
        end
        if (rd_seen) begin
            if (exp_q.size() == 0) check("scoreboard underrun", 1, 0);
            else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    task automatic rd(input logic [1:0] a, input logic [3:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk); rd_en = 1'b1; rd_addr = a;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic rd8(input int c, input logic [7:0] e, input string tag);
        rd(2'(2 * c), e[3:0], tag);
        rd(2'(2 * c + 1), e[7:4], tag);
    endtask

    task automatic run_write(input int c, input logic v);
        @(negedge clk); run_wr[c] = 1'b1; run_wdata[c] = v;
        @(negedge clk); run_wr[c] = 1'b0;
    endtask

    task automatic reload_write(input int c, input logic [7:0] v);
        @(negedge clk); reload_wr[c] = 1'b1; reload_data = v;
        @(negedge clk); reload_wr[c] = 1'b0;
    endtask

    task automatic fall_pre();
        @(negedge clk); pre_clk_i = 1'b0;
        repeat (4) @(negedge clk);
        pre_clk_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic fall_evt();
        @(negedge clk); evt_clk_i = 1'b0;
        repeat (4) @(negedge clk);
        evt_clk_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog expired", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 run_rd", run_rd, 0);
        check("R1 underflow", underflow, 0);
        check("R1 rd_data", rd_data, 0);
        rd8(0, 8'h00, "R1 count0");
        rd8(1, 8'h00, "R1 count1");

        // R7 preset while stopped, R9 nibble order
        reload_write(0, 8'h42);
        rd8(0, 8'h42, "R7/R9 preset");

        // R2 deferred start without decrement
        run_write(0, 1'b1);
        repeat (10) @(negedge clk);
        check("R2 run_rd before edge", run_rd[0], 0);
        fall_pre();
        check("R2 run_rd after edge", run_rd[0], 1);
        rd8(0, 8'h42, "R2 no decrement on start");

        // R3 one step per edge
        repeat (4) fall_pre();
        rd8(0, 8'h3E, "R3 four edges");

        // R4 pending stop reads 1, final decrement
        run_write(0, 1'b0);
        repeat (10) @(negedge clk);
        check("R4 run_rd pending", run_rd[0], 1);
        fall_pre();
        check("R4 run_rd stopped", run_rd[0], 0);
        rd8(0, 8'h3D, "R4 extra decrement");
        fall_pre();
        rd8(0, 8'h3D, "R4 held after stop");

        // R5 event mode, stalled event clock
        src_evt = 1'b1;
        run_write(0, 1'b1);
        fall_pre(); fall_pre();
        check("R5 prescale ignored", run_rd[0], 0);
        repeat (50) @(negedge clk);
        check("R5 stalled event", run_rd[0], 0);
        fall_evt();
        check("R5 start on event", run_rd[0], 1);
        rd8(0, 8'h3D, "R5 no decrement on start");
        fall_evt(); fall_evt();
        rd8(0, 8'h3B, "R5 event counting");
        run_write(0, 1'b0);
        fall_evt();
        check("R5 stop on event", run_rd[0], 0);
        rd8(0, 8'h3A, "R5 stop decrement");

        // R6 underflow reload and pulse
        src_evt = 1'b0;
        reload_write(0, 8'h01);
        uf0_n = 0;
        run_write(0, 1'b1);
        fall_pre(); fall_pre();
        check("R6 no early underflow", uf0_n, 0);
        fall_pre();
        check("R6 one pulse cycle", uf0_n, 1);
        rd8(0, 8'h01, "R6 reloaded");
        // R7 reload while running leaves the count
        reload_write(0, 8'h80);
        rd8(0, 8'h01, "R7 running unchanged");
        run_write(0, 1'b0);
        fall_pre();
        rd8(0, 8'h00, "R4 stop to zero");

        // R8 cascade
        reload_write(0, 8'h02);
        reload_write(1, 8'h05);
        cascade16 = 1'b1;
        uf0_n = 0; uf1_n = 0;
        run_write(0, 1'b1);
        fall_pre();
        repeat (3) fall_pre();
        check("R8 low underflow", uf0_n, 1);
        rd(2'd0, 4'h2, "R8/R10 c0 lo");
        rd(2'd1, 4'h0, "R8/R10 c0 hi");
        rd(2'd2, 4'h4, "R8/R10 c1 lo");
        rd(2'd3, 4'h0, "R8/R10 c1 hi");
        repeat (12) fall_pre();
        check("R8 no high underflow yet", uf1_n, 0);
        repeat (3) fall_pre();
        check("R8 high underflow", uf1_n, 1);
        rd(2'd0, 4'h2, "R8 c0 lo");
        rd(2'd1, 4'h0, "R8 c0 hi");
        rd(2'd2, 4'h5, "R8 c1 reloaded lo");
        rd(2'd3, 4'h0, "R8 c1 reloaded hi");

        // R10 capture window, R11 expiry
        run_write(0, 1'b0);
        fall_pre();
        cascade16 = 1'b0;
        reload_write(0, 8'h10);
        run_write(0, 1'b1);
        fall_pre();
        rd(2'd0, 4'h0, "R10 low read");
        fall_pre();
        rd(2'd1, 4'h1, "R10 captured high");
        repeat (20) @(negedge clk);
        rd(2'd1, 4'h0, "R11 live after window");
        rd(2'd0, 4'hF, "R3 live low");

        repeat (4) @(negedge clk);
        check("scoreboard drained", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule